// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block sits on the device side of an 8-bit parallel flash bus. It watches write strobes and recognises the fixed unlock-and-command sequences that ask for a single byte program, a sector erase, a whole-chip erase, or entry into an identification mode. When a sequence completes, it hands one operation to the storage array over a request channel. It then stays busy until the array reports completion.

While busy, bus reads return a status byte instead of array contents. In identification mode, reads return a manufacturer code and a size-dependent device code. At all other times, reads return the byte the array presents. The block can act as a synthesizable front end for an array model, or as a target against which a host-side controller is checked. Cell timing is not modelled: the array says when it is done.

The request channel is valid/ready. Once `req_valid` rises, the operation, address and data stay frozen until a cycle with `req_ready` high. The array may hold `req_ready` low for as long as it likes, and the decoder stays busy throughout. The read return path has no back-pressure: `rd_valid` is a one-cycle pulse that the host must take.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy`, `req_valid` and `rd_valid` are low, and identification mode is off.
- R2: Writing AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, arms a program. The next write issues a request with `req_op`=1 and with the address and data of that write. Only the low 15 address bits take part in matching 5555h and 2AAAh.
- R3: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, followed by 30h at any address, issues `req_op`=2 with that address and data FFh.
- R4: The same five-step prefix followed by 10h at 5555h issues `req_op`=3 with address 0 and data FFh. A final 10h at any other address issues nothing.
- R5: A write that does not match the expected next step returns the decoder to idle. The later steps of the sequence then issue nothing until a fresh AAh@5555h.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_op`, `req_addr` and `req_data` hold. `busy` is high from the cycle after the final write until the cycle after `arr_done` is seen following acceptance.
- R7: A read while busy returns a status byte. Bit 7 is the inverse of bit 7 of the request data. Bit 6 is 0 on the first busy read of an operation and inverts on each later busy read. Bits 5..0 are 0.
- R8: Writes while busy have no effect on the sequence state or on identification mode.
- R9: A third step of 90h at 5555h enters identification mode. In that mode, a read at address 0 returns BFh, a read at address 1 returns D5h plus (ADDR_W-17), and any other address returns 00h.
- R10: In identification mode, a write of F0h at any address leaves the mode. Any other write is ignored.
- R11: `rd_valid` is high exactly in the cycle after `bus_re`. Outside busy and identification mode, `rd_data` is the `arr_rdata` value present with the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| arr_rdata | input | 8 | Array byte at `bus_addr` |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| req_valid | output | 1 | Array operation pending |
| req_ready | input | 1 | Array accepts the operation |
| req_op | output | 2 | 1 program, 2 sector erase, 3 chip erase |
| req_addr | output | ADDR_W | Operation address |
| req_data | output | 8 | Program byte, FFh for erases |
| arr_done | input | 1 | Array finished the accepted operation |
| busy | output | 1 | Operation in progress |

## Verification
The assertions check the following on every cycle:
- the request channel stays frozen under back-pressure;
- a request never exists without `busy`, and carries a legal operation code;
- `busy` cannot drop before the array reports completion;
- the read pulse follows each read strobe;
- the low status bits stay clear.

Only the bench scenarios can show the rest, because each depends on a history of several writes. This covers:
- recognition of each full sequence, with address aliasing;
- the fall back to idle on a wrong step;
- the status bit values and their alternation;
- the identification codes and leaving that mode;
- proof that writes made while busy left nothing behind.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } fcd_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PGM,
    SQ_ER1,
    SQ_ER2,
    SQ_ER3
  } fcd_seq_e;

  typedef enum logic [1:0] {
    RQ_IDLE,
    RQ_OFFER,
    RQ_WAIT
  } fcd_req_e;

  localparam int          MATCH_W  = 15;
  localparam logic [14:0] ADR_HI   = 15'h5555;
  localparam logic [14:0] ADR_LO   = 15'h2AAA;
  localparam logic [7:0]  C_KEY1   = 8'hAA;
  localparam logic [7:0]  C_KEY2   = 8'h55;
  localparam logic [7:0]  C_PGM    = 8'hA0;
  localparam logic [7:0]  C_ERASE  = 8'h80;
  localparam logic [7:0]  C_SECT   = 8'h30;
  localparam logic [7:0]  C_CHIP   = 8'h10;
  localparam logic [7:0]  C_IDENT  = 8'h90;
  localparam logic [7:0]  C_LEAVE  = 8'hF0;
  localparam logic [7:0]  MAKER_ID = 8'hBF;
  localparam logic [7:0]  ERASED   = 8'hFF;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  output logic              launch,
  output fcd_op_e           l_op,
  output logic [ADDR_W-1:0] l_addr,
  output logic [7:0]        l_data,
  output logic              id_mode
);

  fcd_seq_e           st_q, st_d;
  logic               id_d;
  logic               wr;
  logic               at_hi, at_lo;
  logic [MATCH_W-1:0] low;

  assign wr    = wr_en && !busy;
  assign low   = addr[MATCH_W-1:0];
  assign at_hi = (low == ADR_HI);
  assign at_lo = (low == ADR_LO);

  always_comb begin
    st_d   = st_q;
    id_d   = id_mode;
    launch = 1'b0;
    l_op   = OP_NONE;
    l_addr = '0;
    l_data = '0;
    if (wr) begin
      if (id_mode) begin
        st_d = SQ_IDLE;
        if (wdata == C_LEAVE) id_d = 1'b0;
      end else begin
        st_d = SQ_IDLE;
        unique case (st_q)
          SQ_IDLE: if (at_hi && wdata == C_KEY1) st_d = SQ_KEY1;
          SQ_KEY1: if (at_lo && wdata == C_KEY2) st_d = SQ_KEY2;
          SQ_KEY2: begin
            if (at_hi) begin
              if (wdata == C_PGM)   st_d = SQ_PGM;
              if (wdata == C_ERASE) st_d = SQ_ER1;
              if (wdata == C_IDENT) id_d = 1'b1;
            end
          end
          SQ_PGM: begin
            launch = 1'b1;
            l_op   = OP_PROG;
            l_addr = addr;
            l_data = wdata;
          end
          SQ_ER1: if (at_hi && wdata == C_KEY1) st_d = SQ_ER2;
          SQ_ER2: if (at_lo && wdata == C_KEY2) st_d = SQ_ER3;
          SQ_ER3: begin
            if (wdata == C_SECT) begin
              launch = 1'b1;
              l_op   = OP_SECT;
              l_addr = addr;
              l_data = ERASED;
            end else if (wdata == C_CHIP && at_hi) begin
              launch = 1'b1;
              l_op   = OP_CHIP;
              l_data = ERASED;
            end
          end
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      id_mode <= 1'b0;
    end else begin
      st_q    <= st_d;
      id_mode <= id_d;
    end
  end

endmodule

// File: rtl/fcd_req.sv
module fcd_req
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  fcd_op_e           l_op,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [7:0]        l_data,
  input  logic              req_ready,
  input  logic              arr_done,
  input  logic              rd_en,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic              busy,
  output logic [7:0]        status
);

  fcd_req_e st_q;
  logic     tog_q;

  assign req_valid = (st_q == RQ_OFFER);
  assign busy      = (st_q != RQ_IDLE);
  assign status    = {~req_data[7], tog_q, 6'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= RQ_IDLE;
      tog_q    <= 1'b0;
      req_op   <= '0;
      req_addr <= '0;
      req_data <= '0;
    end else begin
      unique case (st_q)
        RQ_IDLE: if (launch) begin
          st_q     <= RQ_OFFER;
          req_op   <= l_op;
          req_addr <= l_addr;
          req_data <= l_data;
          tog_q    <= 1'b0;
        end
        RQ_OFFER: if (req_ready) st_q <= RQ_WAIT;
        RQ_WAIT:  if (arr_done)  st_q <= RQ_IDLE;
        default:  st_q <= RQ_IDLE;
      endcase
      if (busy && rd_en) tog_q <= ~tog_q;
    end
  end

endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic [7:0]        status,
  input  logic              id_mode,
  input  logic [7:0]        arr_rdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  localparam logic [7:0] DEV_ID = 8'hD5 + 8'(ADDR_W - 17);

  logic [7:0] sel;

  always_comb begin
    if (busy)                   sel = status;
    else if (!id_mode)          sel = arr_rdata;
    else if (addr == ADDR_W'(0)) sel = MAKER_ID;
    else if (addr == ADDR_W'(1)) sel = DEV_ID;
    else                        sel = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [7:0]        arr_rdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  input  logic              arr_done,
  output logic              busy
);

  logic              launch;
  fcd_op_e           l_op;
  logic [ADDR_W-1:0] l_addr;
  logic [7:0]        l_data;
  logic              id_mode;
  logic [7:0]        status;

  fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .busy    (busy),
    .launch  (launch),
    .l_op    (l_op),
    .l_addr  (l_addr),
    .l_data  (l_data),
    .id_mode (id_mode)
  );

  fcd_req #(.ADDR_W(ADDR_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .l_op      (l_op),
    .l_addr    (l_addr),
    .l_data    (l_data),
    .req_ready (req_ready),
    .arr_done  (arr_done),
    .rd_en     (bus_re),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .busy      (busy),
    .status    (status)
  );

  fcd_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (bus_re),
    .addr      (bus_addr),
    .busy      (busy),
    .status    (status),
    .id_mode   (id_mode),
    .arr_rdata (arr_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_re,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_data,
  input logic              arr_done,
  input logic              busy
);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_op) &&
                                   $stable(req_addr) && $stable(req_data)));

  assert_req_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  assert_busy_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !arr_done) |=> busy);

  assert_op_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_op != 2'd0));

  assert_read_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> rd_valid);

  assert_no_stray_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !rd_valid);

  assert_status_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && busy) |=> (rd_data[5:0] == 6'd0));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_re    (bus_re),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .req_data  (req_data),
  .arr_done  (arr_done),
  .busy      (busy)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/100ps
module flash_cmd_decoder_test;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    arr_rdata;
  logic          rd_valid, req_valid, busy;
  logic [7:0]    rd_data, req_data;
  logic          req_ready = 1'b0, arr_done = 1'b0;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]        rd_q[$];
  string             rd_tag[$];
  logic [AW+9:0]     rq_q[$];
  string             rq_tag[$];

  assign arr_rdata = bus_addr[7:0] ^ 8'h3C;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .arr_rdata(arr_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .arr_done(arr_done), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare design results against the scoreboard queues.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (rd_q.size() == 0) check(1'b0, "R11 unexpected read", rd_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = rd_q.pop_front();
        t = rd_tag.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
    if (rst_n && req_valid && req_ready) begin
      if (rq_q.size() == 0) check(1'b0, "R5 unexpected request", {req_op, req_addr, req_data}, 0);
      else begin
        logic [AW+9:0] e;
        string t;
        e = rq_q.pop_front();
        t = rq_tag.pop_front();
        check({req_op, req_addr, req_data} == e, t, {req_op, req_addr, req_data}, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    rd_q.push_back(e);
    rd_tag.push_back(tag);
    @(posedge clk); #1;
    bus_re = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_re = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic expect_req(input logic [1:0] op, input logic [AW-1:0] a,
                            input logic [7:0] d, input string tag);
    rq_q.push_back({op, a, d});
    rq_tag.push_back(tag);
  endtask

  task automatic unlock();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  task automatic finish_op();
    @(posedge clk); #1 req_ready = 1'b1;
    @(posedge clk); #1 req_ready = 1'b0;
    check(busy == 1'b1, "R6 busy after accept", busy, 1);
    arr_done = 1'b1;
    @(posedge clk); #1 arr_done = 1'b0;
    check(busy == 1'b0, "R6 busy clears after done", busy, 0);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check(busy == 1'b0 && req_valid == 1'b0 && rd_valid == 1'b0,
          "R1 reset state", {busy, req_valid, rd_valid}, 0);
    rd(17'h00000, 8'h3C, "R1 no id mode after reset");
    rd(17'h000A5, 8'h99, "R11 array read");

    // R2 program, aliased address 15555h, back-pressure, busy status
    wr(17'h15555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'hA0);
    expect_req(2'd1, 17'h12345, 8'h5A, "R2 program request");
    wr(17'h12345, 8'h5A);
    check(busy == 1'b1 && req_valid == 1'b1, "R6 busy on launch", {busy, req_valid}, 3);
    rd(17'h00000, 8'h80, "R7 status read 1");
    rd(17'h00000, 8'hC0, "R7 status read 2");
    rd(17'h00000, 8'h80, "R7 status read 3");
    // R8 writes while busy: id entry and a program must leave nothing
    unlock();
    wr(17'h05555, 8'h90);
    unlock();
    wr(17'h05555, 8'hA0);
    wr(17'h00100, 8'h11);
    check(req_valid == 1'b1, "R6 request held under back-pressure", req_valid, 1);
    finish_op();
    rd(17'h00000, 8'h3C, "R8 busy writes ignored (no id mode)");
    wr(17'h00100, 8'h11);
    check(busy == 1'b0, "R8 no armed program after busy", busy, 0);

    // Program with bit 7 set
    unlock();
    wr(17'h05555, 8'hA0);
    expect_req(2'd1, 17'h00042, 8'hC3, "R2 program request 2");
    wr(17'h00042, 8'hC3);
    rd(17'h00000, 8'h00, "R7 status bit7 inverted 1");
    rd(17'h00000, 8'h40, "R7 status bit7 inverted 2");
    finish_op();

    // R3 sector erase
    unlock();
    wr(17'h05555, 8'h80);
    unlock();
    expect_req(2'd2, 17'h07123, 8'hFF, "R3 sector erase request");
    wr(17'h07123, 8'h30);
    rd(17'h00000, 8'h00, "R7 erase status");
    finish_op();

    // R4 chip erase; first a wrong address for the final 10h
    unlock();
    wr(17'h05555, 8'h80);
    unlock();
    wr(17'h00123, 8'h10);
    check(busy == 1'b0, "R4 10h off 5555h ignored", busy, 0);
    unlock();
    wr(17'h05555, 8'h80);
    unlock();
    expect_req(2'd3, 17'h00000, 8'hFF, "R4 chip erase request");
    wr(17'h05555, 8'h10);
    finish_op();

    // R5 mismatches
    wr(17'h05555, 8'hAA);
    wr(17'h01234, 8'h55);
    wr(17'h05555, 8'hA0);
    wr(17'h00100, 8'h77);
    check(busy == 1'b0, "R5 wrong address aborts", busy, 0);
    unlock();
    wr(17'h05555, 8'h80);
    unlock();
    wr(17'h00100, 8'h20);
    wr(17'h00100, 8'h30);
    check(busy == 1'b0, "R5 wrong data aborts", busy, 0);
    rd(17'h00001, 8'h3D, "R5 still normal reads");

    // R9 / R10 identification mode
    unlock();
    wr(17'h05555, 8'h90);
    rd(17'h00000, 8'hBF, "R9 maker code");
    rd(17'h00001, 8'hD5, "R9 device code");
    rd(17'h00002, 8'h00, "R9 other address");
    unlock();
    wr(17'h05555, 8'hA0);
    wr(17'h00100, 8'h55);
    check(busy == 1'b0, "R10 writes ignored in id mode", busy, 0);
    rd(17'h00000, 8'hBF, "R10 still in id mode");
    wr(17'h00033, 8'hF0);
    rd(17'h00000, 8'h3C, "R10 id mode left");

    repeat (4) @(posedge clk);
    check(rd_q.size() == 0 && rq_q.size() == 0, "R11 scoreboard drained",
          rd_q.size() + rq_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule